// File: doc/BRIEF.md
# Pseudo-Stop Oscillator Loss Supervisor

This block decides how the chip reacts when its external oscillator stops while the chip rests in pseudo-stop, a low-power state. It runs on an internal clock that is always present. It watches a synchronized pulse stream of oscillator edges. It declares the oscillator lost when no edge arrives for a programmable number of internal-clock cycles.

Three control bits are captured when the chip enters stop. Together they select one of three reactions to a loss:

- ignore the loss;
- request a clock monitor reset at once;
- fall back to self-clock mode.

In self-clock mode the regulator and PLL are enabled and a sticky interrupt flag is set. A quality check then runs over and over. Each pass needs a fixed number of uninterrupted oscillator edges.

The outcome of the quality check, together with any wakeup or external reset, decides two things: whether the chip stays in stop, and which clock it leaves stop on. The clock is either the oscillator or the PLL in self-clock mode.

Top module: `stop_clk_supervisor`

## Requirements
- R1: While reset is applied and right after it, every output is 0.
- R2: If the monitor bit captured at stop entry is 0, an oscillator loss in stop causes nothing: no reset request, no self-clock mode and no exit from stop.
- R3: If the captured monitor bit is 1 and the captured self-clock bit is 0, a loss raises `rst_req_o` for exactly one cycle, between GAP_CYCLES and GAP_CYCLES+2 cycles after the last oscillator edge. The block then leaves stop without a `stop_exit_o` pulse.
- R4: A loss is declared only after GAP_CYCLES consecutive internal-clock cycles with no oscillator edge. A shorter gap has no effect.
- R5: If both captured bits are 1, a loss in stop sets `vreg_en_o`, `pll_en_o`, `scm_active_o` and `scm_flag_o`, and the block stays in stop.
- R6: The quality check passes after QC_EDGES oscillator edges have been counted with no loss. A pass in stop clears `scm_active_o`, `pll_en_o` and `vreg_en_o`, and the block stays in stop.
- R7: A loss during a quality check restarts its edge count from zero. A check that does not pass is repeated without limit.
- R8: If the captured interrupt-enable bit is 0, `scm_wake_irq_o` stays 0. Stop is left only on `wake_i` or `ext_rst_i`, each of which gives a one-cycle `stop_exit_o` pulse.
- R9: If the captured interrupt-enable bit is 1, `scm_wake_irq_o` equals `scm_flag_o`. While it is high, the block exits stop.
- R10: `sysclk_sel_o` is 0 for the oscillator and 1 for the PLL in self-clock mode. An exit with the oscillator good gives 0. An exit from self-clock mode gives 1, which holds until a quality check passes; then it returns to 0 and self-clock mode ends.
- R11: `ext_rst_i` in stop exits with a `stop_exit_o` pulse and a one-cycle `rst_req_o`. It uses the clock choice of R10.
- R12: `scm_flag_o` is sticky. A one-cycle `flag_clr_i` clears it, and setting the flag wins over clearing it.
- R13: The three control bits are captured when stop is entered. Changing them while in stop has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_edge_i | input | 1 | One-cycle pulse per synchronized oscillator edge |
| stop_enter_i | input | 1 | Request to enter pseudo-stop |
| wake_i | input | 1 | Wakeup interrupt from another source |
| ext_rst_i | input | 1 | External reset request |
| cm_en_i | input | 1 | Clock monitor enable |
| scm_en_i | input | 1 | Self-clock-mode enable |
| scm_ie_i | input | 1 | Self-clock interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| rst_req_o | output | 1 | One-cycle reset request |
| vreg_en_o | output | 1 | Regulator enable |
| pll_en_o | output | 1 | PLL enable |
| scm_active_o | output | 1 | Self-clock mode active |
| scm_flag_o | output | 1 | Sticky self-clock flag |
| scm_wake_irq_o | output | 1 | Self-clock wakeup interrupt |
| stop_exit_o | output | 1 | One-cycle pulse on leaving stop |
| sysclk_sel_o | output | 1 | System clock select (0 oscillator, 1 PLL) |

## Verification
The bench stops the oscillator for 50 cycles, a gap just under the loss threshold. A detector that counts badly would raise a reset there. The bench then times the real loss, so a reset that comes late, or a request held for more than one cycle, is caught.

The restart test breaks the edge stream partway through a quality check. A checker that kept its count across the gap would pass about 4,000 cycles early.

The bench changes the live control bits during stop. A design that read them live would reset where it should ignore the loss.

Exits come by wakeup, by self-clock interrupt and by external reset, each from both sub-states. A wrong clock-select choice, or self-clock mode ending before the check passes, shows up as a mismatch at the exit.

// File: rtl/stop_sup_pkg.sv
package stop_sup_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_STOP     = 2'd1,
    ST_STOP_SCM = 2'd2,
    ST_RUN_SCM  = 2'd3
  } sup_state_e;

  typedef struct packed {
    logic mon_en;
    logic scm_en;
    logic irq_en;
  } sup_ctrl_t;

endpackage

// File: rtl/osc_gap_monitor.sv
module osc_gap_monitor #(
  parameter int GAP_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_edge_i,
  output logic loss_o
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(GAP_CYCLES);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= '0;
    else if (osc_edge_i)        gap_q <= '0;
    else if (gap_q != GAP_MAX)  gap_q <= gap_q + 1'b1;
  end

  assign loss_o = (gap_q == GAP_MAX);

  // R4
  edge_clears_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_edge_i |=> !loss_o);

endmodule

// File: rtl/osc_quality_check.sv
module osc_quality_check #(
  parameter int QC_EDGES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic osc_edge_i,
  input  logic loss_i,
  output logic pass_o
);
  localparam int QW = $clog2(QC_EDGES);
  localparam logic [QW-1:0] LAST = QW'(QC_EDGES - 1);

  logic [QW-1:0] cnt_q;
  logic          pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      pass_q <= 1'b0;
      if (!run_i || loss_i) begin
        cnt_q <= '0;  // gap or idle: restart the window
      end else if (osc_edge_i) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          pass_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pass_o = pass_q;

  // R6
  pass_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o);

  // R7
  no_pass_after_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_i |=> !pass_o);

endmodule

// File: rtl/supervisor_fsm.sv
module supervisor_fsm
  import stop_sup_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loss_i,
  input  logic qc_pass_i,
  input  logic stop_enter_i,
  input  logic wake_i,
  input  logic ext_rst_i,
  input  logic cm_en_i,
  input  logic scm_en_i,
  input  logic scm_ie_i,
  input  logic flag_clr_i,
  output logic qc_run_o,
  output logic rst_req_o,
  output logic vreg_en_o,
  output logic pll_en_o,
  output logic scm_active_o,
  output logic scm_flag_o,
  output logic scm_wake_irq_o,
  output logic stop_exit_o,
  output logic sysclk_sel_o
);
  sup_state_e st_q, st_d;
  sup_ctrl_t  ctrl_q;
  logic       flag_q, flag_set;
  logic       rst_q, rst_d;
  logic       exit_q, exit_d;
  logic       wake_any, in_stop;

  assign scm_wake_irq_o = flag_q & ctrl_q.irq_en;
  assign wake_any       = wake_i | scm_wake_irq_o;
  assign in_stop        = (st_q == ST_STOP) || (st_q == ST_STOP_SCM);

  always_comb begin
    st_d     = st_q;
    rst_d    = 1'b0;
    exit_d   = 1'b0;
    flag_set = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (stop_enter_i) st_d = ST_STOP;
      end
      ST_STOP: begin
        if (ext_rst_i) begin
          st_d = ST_RUN; exit_d = 1'b1; rst_d = 1'b1;
        end else if (wake_any) begin
          st_d = ST_RUN; exit_d = 1'b1;
        end else if (loss_i && ctrl_q.mon_en) begin
          if (ctrl_q.scm_en) begin
            st_d = ST_STOP_SCM; flag_set = 1'b1;
          end else begin
            st_d = ST_RUN; rst_d = 1'b1;  // clock monitor reset
          end
        end
      end
      ST_STOP_SCM: begin
        if (ext_rst_i) begin
          st_d = ST_RUN_SCM; exit_d = 1'b1; rst_d = 1'b1;
        end else if (wake_any) begin
          st_d = ST_RUN_SCM; exit_d = 1'b1;
        end else if (qc_pass_i) begin
          st_d = ST_STOP;
        end
      end
      ST_RUN_SCM: begin
        if (qc_pass_i) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      ctrl_q <= '0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
      exit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rst_q  <= rst_d;
      exit_q <= exit_d;
      if (st_q == ST_RUN && stop_enter_i)
        ctrl_q <= '{mon_en: cm_en_i, scm_en: scm_en_i, irq_en: scm_ie_i};
      if (flag_set)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign qc_run_o     = (st_q == ST_STOP_SCM) || (st_q == ST_RUN_SCM);
  assign scm_active_o = qc_run_o;
  assign pll_en_o     = qc_run_o;
  assign vreg_en_o    = qc_run_o;
  assign sysclk_sel_o = (st_q == ST_RUN_SCM);
  assign rst_req_o    = rst_q;
  assign stop_exit_o  = exit_q;
  assign scm_flag_o   = flag_q;

  // R3
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R5
  scm_entry_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scm_active_o) |-> scm_flag_o);

  // R10
  sel_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysclk_sel_o |-> (pll_en_o && scm_active_o));

  // R13
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_stop && $past(in_stop)) |-> $stable(ctrl_q));

  // R11
  exit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_exit_o |=> !stop_exit_o);

endmodule

// File: rtl/stop_clk_supervisor.sv
module stop_clk_supervisor #(
  parameter int GAP_CYCLES = 64,
  parameter int QC_EDGES   = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_edge_i,
  input  logic stop_enter_i,
  input  logic wake_i,
  input  logic ext_rst_i,
  input  logic cm_en_i,
  input  logic scm_en_i,
  input  logic scm_ie_i,
  input  logic flag_clr_i,
  output logic rst_req_o,
  output logic vreg_en_o,
  output logic pll_en_o,
  output logic scm_active_o,
  output logic scm_flag_o,
  output logic scm_wake_irq_o,
  output logic stop_exit_o,
  output logic sysclk_sel_o
);
  logic loss, qc_pass, qc_run;

  osc_gap_monitor #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_edge_i (osc_edge_i),
    .loss_o     (loss)
  );

  osc_quality_check #(.QC_EDGES(QC_EDGES)) u_qc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (qc_run),
    .osc_edge_i (osc_edge_i),
    .loss_i     (loss),
    .pass_o     (qc_pass)
  );

  supervisor_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .loss_i         (loss),
    .qc_pass_i      (qc_pass),
    .stop_enter_i   (stop_enter_i),
    .wake_i         (wake_i),
    .ext_rst_i      (ext_rst_i),
    .cm_en_i        (cm_en_i),
    .scm_en_i       (scm_en_i),
    .scm_ie_i       (scm_ie_i),
    .flag_clr_i     (flag_clr_i),
    .qc_run_o       (qc_run),
    .rst_req_o      (rst_req_o),
    .vreg_en_o      (vreg_en_o),
    .pll_en_o       (pll_en_o),
    .scm_active_o   (scm_active_o),
    .scm_flag_o     (scm_flag_o),
    .scm_wake_irq_o (scm_wake_irq_o),
    .stop_exit_o    (stop_exit_o),
    .sysclk_sel_o   (sysclk_sel_o)
  );

  // R1
  idle_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scm_active_o) |-> (!pll_en_o && !vreg_en_o && !sysclk_sel_o));

endmodule

// File: tb/stop_clk_supervisor_test.sv
module stop_clk_supervisor_test;
  localparam int GAP = 64;
  localparam int QC  = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_edge = 1'b0, osc_on = 1'b0;
  logic stop_enter = 0, wake = 0, ext_rst = 0, cm_en = 0, scm_en = 0, scm_ie = 0, flag_clr = 0;
  logic rst_req_o, vreg_en_o, pll_en_o, scm_active_o, scm_flag_o, scm_wake_irq_o, stop_exit_o, sysclk_sel_o;
  int n_chk = 0, n_fail = 0, n_rst = 0, n_exit = 0;
  logic exit_sel = 1'b0;
  logic done = 1'b0;

  stop_clk_supervisor uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_edge_i(osc_edge), .stop_enter_i(stop_enter),
    .wake_i(wake), .ext_rst_i(ext_rst), .cm_en_i(cm_en), .scm_en_i(scm_en),
    .scm_ie_i(scm_ie), .flag_clr_i(flag_clr), .rst_req_o(rst_req_o),
    .vreg_en_o(vreg_en_o), .pll_en_o(pll_en_o), .scm_active_o(scm_active_o),
    .scm_flag_o(scm_flag_o), .scm_wake_irq_o(scm_wake_irq_o),
    .stop_exit_o(stop_exit_o), .sysclk_sel_o(sysclk_sel_o)
  );

  initial forever #10 clk = ~clk;

  // oscillator edge stream: one pulse every two cycles while osc_on
  initial forever begin
    @(negedge clk); #1;
    osc_edge = osc_on & ~osc_edge;
  end

  // pulse counters
  initial forever begin
    @(negedge clk); #2;
    if (rst_req_o) n_rst++;
    if (stop_exit_o) begin n_exit++; exit_sel = sysclk_sel_o; end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_stop(input logic cm, input logic scm, input logic ie);
    cm_en = cm; scm_en = scm; scm_ie = ie;
    stop_enter = 1'b1; tick(1); stop_enter = 1'b0; tick(2);
  endtask

  task automatic pulse_wake();
    wake = 1'b1; tick(1); wake = 1'b0; tick(3);
  endtask

  task automatic pulse_ext_rst();
    ext_rst = 1'b1; tick(1); ext_rst = 1'b0; tick(3);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(2);
  endtask

  task automatic wait_scm(input logic v, input int limit, output int n);
    n = 0;
    while (scm_active_o !== v && n < limit) begin tick(1); n++; end
  endtask

  task automatic t_reset();
    chk("R1 rst_req", rst_req_o, 0);
    chk("R1 scm_active", scm_active_o, 0);
    chk("R1 pll/vreg", {pll_en_o, vreg_en_o}, 0);
    chk("R1 flag/irq", {scm_flag_o, scm_wake_irq_o}, 0);
    chk("R1 exit/sel", {stop_exit_o, sysclk_sel_o}, 0);
  endtask

  task automatic t_monitor_off();
    int r0 = n_rst, e0 = n_exit;
    enter_stop(0, 1, 1);
    cm_en = 1'b1;  // live change must be ignored (R13)
    osc_on = 1'b0; tick(200);
    chk("R2 no reset", n_rst, r0);
    chk("R2 no scm", scm_active_o, 0);
    chk("R13 no exit", n_exit, e0);
    osc_on = 1'b1; tick(6);
    pulse_wake();
    chk("R8 wake exit", n_exit, e0 + 1);
    chk("R10 sel osc", exit_sel, 0);
  endtask

  task automatic t_reset_mode();
    int r0 = n_rst, e0 = n_exit, lat = 0;
    enter_stop(1, 0, 0);
    scm_en = 1'b1;
    osc_on = 1'b0; tick(50); osc_on = 1'b1; tick(20);
    chk("R4 short gap", n_rst, r0);
    osc_on = 1'b0;
    while (!rst_req_o && lat < 500) begin tick(1); lat++; end
    chk_rng("R3 latency", lat, GAP, GAP + 2);
    tick(10);
    chk("R3 one pulse", n_rst, r0 + 1);
    chk("R13 no scm", scm_active_o, 0);
    osc_on = 1'b1; tick(6);
    pulse_wake();
    chk("R3 left stop", n_exit, e0);
  endtask

  task automatic t_scm_quiet();
    int e0, n;
    clear_flag();
    e0 = n_exit;
    enter_stop(1, 1, 0);
    osc_on = 1'b0;
    wait_scm(1'b1, 200, n);
    chk("R5 scm on", scm_active_o, 1);
    chk("R5 pll/vreg on", {pll_en_o, vreg_en_o}, 3);
    chk("R5 flag", scm_flag_o, 1);
    chk("R8 no irq", scm_wake_irq_o, 0);
    tick(20);
    chk("R5 stays stop", n_exit, e0);
    osc_on = 1'b1;
    wait_scm(1'b0, 3 * QC, n);
    chk_rng("R6 pass time", n, 2 * QC - 4, 2 * QC + 8);
    chk("R6 pll/vreg off", {pll_en_o, vreg_en_o}, 0);
    chk("R12 sticky", scm_flag_o, 1);
    chk("R6 stays stop", n_exit, e0);
    pulse_wake();
    chk("R8 wake exit", n_exit, e0 + 1);
    chk("R10 sel osc", exit_sel, 0);
    clear_flag();
    chk("R12 cleared", scm_flag_o, 0);
  endtask

  task automatic t_restart();
    int n;
    enter_stop(1, 1, 0);
    osc_on = 1'b0;
    wait_scm(1'b1, 200, n);
    osc_on = 1'b1; tick(4000);
    chk("R7 mid check", scm_active_o, 1);
    osc_on = 1'b0; tick(80); osc_on = 1'b1;
    wait_scm(1'b0, 3 * QC, n);
    chk_rng("R7 restart", n, 2 * QC - 4, 2 * QC + 8);
    pulse_wake();
    clear_flag();
  endtask

  task automatic t_scm_wake();
    int e0 = n_exit, n = 0;
    enter_stop(1, 1, 1);
    osc_on = 1'b0;
    while (!stop_exit_o && n < 300) begin tick(1); n++; end
    chk("R9 irq", scm_wake_irq_o, 1);
    chk("R10 sel pll", sysclk_sel_o, 1);
    chk("R10 scm kept", {scm_active_o, pll_en_o}, 3);
    tick(3);
    chk("R9 exit", n_exit, e0 + 1);
    osc_on = 1'b1;
    n = 0;
    while (sysclk_sel_o && n < 3 * QC) begin tick(1); n++; end
    chk_rng("R10 pass time", n, 2 * QC - 4, 2 * QC + 8);
    chk("R10 scm off", {scm_active_o, vreg_en_o}, 0);
    clear_flag();
    chk("R12 irq cleared", scm_wake_irq_o, 0);
  endtask

  task automatic t_ext_rst();
    int e0 = n_exit, r0 = n_rst, n;
    enter_stop(1, 1, 0);
    pulse_ext_rst();
    chk("R11 exit", n_exit, e0 + 1);
    chk("R11 reset", n_rst, r0 + 1);
    chk("R11 sel osc", exit_sel, 0);
    enter_stop(1, 1, 0);
    osc_on = 1'b0;
    wait_scm(1'b1, 200, n);
    pulse_ext_rst();
    chk("R11 scm exit", n_exit, e0 + 2);
    chk("R11 scm reset", n_rst, r0 + 2);
    chk("R11 sel pll", exit_sel, 1);
    osc_on = 1'b1;
    wait_scm(1'b0, 3 * QC, n);
    chk("R10 back to osc", sysclk_sel_o, 0);
    clear_flag();
  endtask

  initial begin
    osc_on = 1'b1;
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_monitor_off();
    t_reset_mode();
    t_scm_quiet();
    t_restart();
    t_scm_wake();
    t_ext_rst();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule